// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on a processor I/O-space bus and provides the two-step path into configuration space. Software first writes a 32-bit selector into an address register reached at port 0CF8h, then reads or writes the four-byte data window at ports 0CFCh to 0CFFh. When the selector's enable bit is set and the access fits inside the window, the block turns the access into a configuration request. The request carries the bus, device, function and register fields held in the selector, plus byte enables and write data. The I/O cycle then stalls until the configuration target responds.

Any access the block does not claim is passed downstream unchanged as an ordinary I/O cycle. That covers byte and word accesses to the selector port, window accesses while the enable bit is clear, window accesses that do not fit, and all other ports. A configuration target that never answers does not hang the bus. After a fixed number of cycles the cycle completes anyway, and a read returns all ones.

Top module: `cfg_port_decoder`

## Requirements
- R1: After reset the selector register is 00000000h, no request output is active, and a dword read of 0CF8h returns 00000000h.
- R2: A dword access to 0CF8h is claimed locally and acknowledged one cycle after the request. A write stores the data with bits 30:24 and 1:0 forced to zero. A read returns the stored value.
- R3: A byte or word access to any of ports 0CF8h-0CFBh is forwarded downstream with the same address, size code, direction and data, and leaves the selector unchanged.
- R4: While selector bit 31 is clear, accesses to the data window are forwarded downstream and produce no configuration request.
- R5: With bit 31 set, a fitting window access produces exactly one single-cycle configuration request. The request carries the bus number from selector bits 23:16, the device from bits 15:11, the function from bits 10:8, the register from bits 7:2, and the direction flag.
- R6: Size codes are 0 byte, 1 word, 2 dword and 3 reserved. The offset is address bits 1:0. A window access fits when offset plus length is at most 4, and byte-enable bit i is set for each covered byte lane i. A misfit access and size code 3 are never claimed.
- R7: Data is lane-aligned to the dword: write data passes unchanged to the target. Read data from the target is returned, and the I/O acknowledge comes one cycle after the response.
- R8: If no response arrives, a configuration cycle is acknowledged TIMEOUT_CYC cycles after the request pulse. A read then returns FFFFFFFFh.
- R9: A forwarded cycle holds its request and fields stable until the downstream acknowledge. It returns the downstream read data and acknowledges the I/O cycle one cycle later.
- R10: Accesses to any port outside 0CF8h-0CFFh are forwarded downstream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| io_req_i | input | 1 | One-cycle start of an I/O cycle, only while idle |
| io_we_i | input | 1 | 1 write, 0 read |
| io_addr_i | input | IO_ADDR_W | I/O port address |
| io_size_i | input | 2 | 0 byte, 1 word, 2 dword, 3 reserved |
| io_wdata_i | input | 32 | Lane-aligned write data |
| io_ack_o | output | 1 | One-cycle completion |
| io_rdata_o | output | 32 | Lane-aligned read data, valid with io_ack_o |
| cfg_req_o | output | 1 | One-cycle configuration request |
| cfg_we_o | output | 1 | Configuration write flag |
| cfg_bus_o | output | 8 | Bus number |
| cfg_dev_o | output | 5 | Device number |
| cfg_func_o | output | 3 | Function number |
| cfg_reg_o | output | 6 | Dword register number |
| cfg_be_o | output | 4 | Byte enables |
| cfg_wdata_o | output | 32 | Configuration write data |
| cfg_rsp_i | input | 1 | Target response valid |
| cfg_rdata_i | input | 32 | Target read data |
| fwd_req_o | output | 1 | Forwarded I/O cycle pending |
| fwd_we_o | output | 1 | Forwarded direction |
| fwd_addr_o | output | IO_ADDR_W | Forwarded address |
| fwd_size_o | output | 2 | Forwarded size code |
| fwd_wdata_o | output | 32 | Forwarded write data |
| fwd_ack_i | input | 1 | Downstream completion |
| fwd_rdata_i | input | 32 | Downstream read data |

## Verification
The hardest situation to reach is a rejected access that looks like an accepted one. One case is a word to the selector port, which must not touch the register. Another is a window access after software has cleared the enable bit or chosen an offset that runs past the window. The stimulus table first programs a selector with reserved bits set. It then interleaves narrow selector writes, disabled-window reads and straddling accesses, and reads the selector back with a dword between them. This shows at the ports that the register kept its value and the request went downstream. A silent target is covered by leaving the response low and timing the acknowledge.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_WORD = 2'd1, SZ_DWORD = 2'd2, SZ_RSVD = 2'd3} io_size_e;
  typedef enum logic [1:0] {TGT_LOCAL, TGT_CFG, TGT_FWD} tgt_e;
  typedef enum logic [2:0] {ST_IDLE, ST_CREQ, ST_CWAIT, ST_FWD, ST_DONE} state_e;
  typedef struct packed {
    logic       en;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] func;
    logic [5:0] regn;
  } cfg_sel_t;
  localparam logic [31:0] SEL_KEEP_MASK = 32'h80FF_FFFC;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_port_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] value_o,
  output cfg_sel_t    sel_o
);
  logic [31:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sel_q <= '0;
    else if (wr_en_i) sel_q <= wdata_i & SEL_KEEP_MASK;
  end

  assign value_o    = sel_q;
  assign sel_o.en   = sel_q[31];
  assign sel_o.bus  = sel_q[23:16];
  assign sel_o.dev  = sel_q[15:11];
  assign sel_o.func = sel_q[10:8];
  assign sel_o.regn = sel_q[7:2];
endmodule

// File: rtl/cfg_io_decode.sv
module cfg_io_decode
  import cfg_port_pkg::*;
#(
  parameter int unsigned           IO_ADDR_W = 16,
  parameter logic [IO_ADDR_W-1:0]  ADDR_PORT = 16'h0CF8,
  parameter logic [IO_ADDR_W-1:0]  DATA_PORT = 16'h0CFC
) (
  input  logic [IO_ADDR_W-1:0] addr_i,
  input  logic [1:0]           size_i,
  input  logic                 enable_i,
  output tgt_e                 tgt_o,
  output logic [3:0]           be_o
);
  localparam int unsigned LANES = 4;

  logic [1:0] off;
  logic [2:0] nbytes;
  logic [2:0] end_pos;
  logic       fits;
  logic       win_hit;
  logic       sel_hit;

  assign off = addr_i[1:0];

  always_comb begin
    unique case (size_i)
      SZ_BYTE:  nbytes = 3'd1;
      SZ_WORD:  nbytes = 3'd2;
      SZ_DWORD: nbytes = 3'd4;
      default:  nbytes = 3'd0;
    endcase
  end

  assign end_pos = {1'b0, off} + nbytes;
  assign fits    = (nbytes != 3'd0) && (end_pos <= 3'd4);
  assign win_hit = addr_i[IO_ADDR_W-1:2] == DATA_PORT[IO_ADDR_W-1:2];
  assign sel_hit = (addr_i == ADDR_PORT) && (size_i == SZ_DWORD);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign be_o[i] = fits && (3'(i) >= {1'b0, off}) && (3'(i) < end_pos);
  end

  always_comb begin
    if (sel_hit)                        tgt_o = TGT_LOCAL;
    else if (win_hit && enable_i && fits) tgt_o = TGT_CFG;
    else                                tgt_o = TGT_FWD;
  end
endmodule

// File: rtl/cfg_rsp_timer.sv
module cfg_rsp_timer #(
  parameter int unsigned TIMEOUT_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned CW = (TIMEOUT_CYC > 2) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (!run_i)      cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/cfg_port_decoder.sv
module cfg_port_decoder
  import cfg_port_pkg::*;
#(
  parameter int unsigned          IO_ADDR_W   = 16,
  parameter logic [IO_ADDR_W-1:0] ADDR_PORT   = 16'h0CF8,
  parameter logic [IO_ADDR_W-1:0] DATA_PORT   = 16'h0CFC,
  parameter int unsigned          TIMEOUT_CYC = 64
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 io_req_i,
  input  logic                 io_we_i,
  input  logic [IO_ADDR_W-1:0] io_addr_i,
  input  logic [1:0]           io_size_i,
  input  logic [31:0]          io_wdata_i,
  output logic                 io_ack_o,
  output logic [31:0]          io_rdata_o,
  output logic                 cfg_req_o,
  output logic                 cfg_we_o,
  output logic [7:0]           cfg_bus_o,
  output logic [4:0]           cfg_dev_o,
  output logic [2:0]           cfg_func_o,
  output logic [5:0]           cfg_reg_o,
  output logic [3:0]           cfg_be_o,
  output logic [31:0]          cfg_wdata_o,
  input  logic                 cfg_rsp_i,
  input  logic [31:0]          cfg_rdata_i,
  output logic                 fwd_req_o,
  output logic                 fwd_we_o,
  output logic [IO_ADDR_W-1:0] fwd_addr_o,
  output logic [1:0]           fwd_size_o,
  output logic [31:0]          fwd_wdata_o,
  input  logic                 fwd_ack_i,
  input  logic [31:0]          fwd_rdata_i
);
  state_e               state_q;
  logic                 we_q;
  logic [IO_ADDR_W-1:0] addr_q;
  logic [1:0]           size_q;
  logic [31:0]          wdata_q;
  logic [3:0]           be_q;
  logic [31:0]          rdata_q;

  logic [31:0] sel_val;
  cfg_sel_t    sel;
  tgt_e        tgt;
  logic [3:0]  be_dec;
  logic        sel_wr;
  logic        tmo;

  assign sel_wr = (state_q == ST_IDLE) && io_req_i && io_we_i && (tgt == TGT_LOCAL);

  cfg_addr_reg u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (sel_wr),
    .wdata_i (io_wdata_i),
    .value_o (sel_val),
    .sel_o   (sel)
  );

  cfg_io_decode #(
    .IO_ADDR_W (IO_ADDR_W),
    .ADDR_PORT (ADDR_PORT),
    .DATA_PORT (DATA_PORT)
  ) u_dec (
    .addr_i   (io_addr_i),
    .size_i   (io_size_i),
    .enable_i (sel.en),
    .tgt_o    (tgt),
    .be_o     (be_dec)
  );

  cfg_rsp_timer #(
    .TIMEOUT_CYC (TIMEOUT_CYC)
  ) u_tmr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     ((state_q == ST_CREQ) || (state_q == ST_CWAIT)),
    .expired_o (tmo)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      we_q    <= 1'b0;
      addr_q  <= '0;
      size_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (io_req_i) begin
          we_q    <= io_we_i;
          addr_q  <= io_addr_i;
          size_q  <= io_size_i;
          wdata_q <= io_wdata_i;
          be_q    <= be_dec;
          unique case (tgt)
            TGT_LOCAL: begin
              rdata_q <= io_we_i ? '0 : sel_val;
              state_q <= ST_DONE;
            end
            TGT_CFG: state_q <= ST_CREQ;
            default: state_q <= ST_FWD;
          endcase
        end
        ST_CREQ, ST_CWAIT: begin
          if (cfg_rsp_i) begin
            rdata_q <= we_q ? '0 : cfg_rdata_i;
            state_q <= ST_DONE;
          end else if (state_q == ST_CWAIT && tmo) begin
            rdata_q <= we_q ? '0 : '1;
            state_q <= ST_DONE;
          end else begin
            state_q <= ST_CWAIT;
          end
        end
        ST_FWD: if (fwd_ack_i) begin
          rdata_q <= we_q ? '0 : fwd_rdata_i;
          state_q <= ST_DONE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign io_ack_o    = state_q == ST_DONE;
  assign io_rdata_o  = rdata_q;

  assign cfg_req_o   = state_q == ST_CREQ;
  assign cfg_we_o    = we_q;
  assign cfg_bus_o   = sel.bus;
  assign cfg_dev_o   = sel.dev;
  assign cfg_func_o  = sel.func;
  assign cfg_reg_o   = sel.regn;
  assign cfg_be_o    = be_q;
  assign cfg_wdata_o = wdata_q;

  assign fwd_req_o   = state_q == ST_FWD;
  assign fwd_we_o    = we_q;
  assign fwd_addr_o  = addr_q;
  assign fwd_size_o  = size_q;
  assign fwd_wdata_o = wdata_q;
endmodule

// File: rtl/cfg_port_decoder_chk.sv
module cfg_port_decoder_chk #(
  parameter int unsigned IO_ADDR_W = 16
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 io_ack_o,
  input logic                 cfg_req_o,
  input logic [3:0]           cfg_be_o,
  input logic                 fwd_req_o,
  input logic                 fwd_ack_i,
  input logic [IO_ADDR_W-1:0] fwd_addr_o,
  input logic [31:0]          fwd_wdata_o
);
  // R5
  cfg_req_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |=> !cfg_req_o);

  // R4
  path_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_req_o && fwd_req_o));

  // R9
  fwd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_req_o && !fwd_ack_i) |=> (fwd_req_o && $stable(fwd_addr_o) && $stable(fwd_wdata_o)));

  // R2
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_ack_o |=> !io_ack_o);

  // R6
  cfg_be_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_req_o |-> (cfg_be_o != 4'h0));

  // R1
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!io_ack_o && !cfg_req_o && !fwd_req_o));
endmodule

bind cfg_port_decoder cfg_port_decoder_chk #(.IO_ADDR_W(IO_ADDR_W)) u_chk (.*);

// File: tb/tb_cfg_port_decoder.sv
module tb_cfg_port_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 64;
  localparam logic [1:0] K_LOC = 2'd0, K_CFG = 2'd1, K_FWD = 2'd2;
  localparam logic [31:0] KEEP = 32'h80FF_FFFC;

  typedef struct packed {
    logic        we;
    logic [15:0] addr;
    logic [1:0]  size;
    logic [31:0] wdata;
    logic [31:0] rsp;
    logic [1:0]  kind;
    logic [31:0] exp_rdata;
    logic [3:0]  exp_be;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 16'h0CF8, 2'd2, 32'hFF125A0F, 32'h0,        K_LOC, 32'h0,        4'h0}, // R2 reserved bits dropped
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        32'h0,        K_LOC, 32'h80125A0C, 4'h0}, // R2
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        32'hDEADBEEF, K_CFG, 32'hDEADBEEF, 4'hF}, // R5 R7
    '{1'b1, 16'h0CFE, 2'd1, 32'hABCD0000, 32'h0,        K_CFG, 32'h0,        4'hC}, // R6 R7
    '{1'b0, 16'h0CFD, 2'd0, 32'h0,        32'h00005500, K_CFG, 32'h00005500, 4'h2}, // R6
    '{1'b1, 16'h0CF8, 2'd0, 32'h00000011, 32'h0,        K_FWD, 32'h0,        4'h0}, // R3
    '{1'b0, 16'h0CFA, 2'd1, 32'h0,        32'h12340000, K_FWD, 32'h12340000, 4'h0}, // R3
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        32'h0,        K_LOC, 32'h80125A0C, 4'h0}, // R3 unchanged
    '{1'b0, 16'h0CFF, 2'd1, 32'h0,        32'h0000AA00, K_FWD, 32'h0000AA00, 4'h0}, // R6 misfit
    '{1'b1, 16'h0080, 2'd0, 32'h0000005A, 32'h0,        K_FWD, 32'h0,        4'h0}, // R10
    '{1'b1, 16'h0CF8, 2'd2, 32'h00125A0C, 32'h0,        K_LOC, 32'h0,        4'h0}, // disable
    '{1'b0, 16'h0CFC, 2'd2, 32'h0,        32'hCAFEF00D, K_FWD, 32'hCAFEF00D, 4'h0}, // R4
    '{1'b0, 16'h0CF8, 2'd2, 32'h0,        32'h0,        K_LOC, 32'h00125A0C, 4'h0}, // R2
    '{1'b0, 16'h0CF8, 2'd3, 32'h0,        32'h00000077, K_FWD, 32'h00000077, 4'h0}, // R6 size 3
    '{1'b1, 16'h0CF8, 2'd2, 32'h8012_5A0C, 32'h0,       K_LOC, 32'h0,        4'h0}, // re-enable
    '{1'b0, 16'h0CFD, 2'd2, 32'h0,        32'h00000066, K_FWD, 32'h00000066, 4'h0}, // R6 dword offset 1
    '{1'b0, 16'h0CFF, 2'd0, 32'h0,        32'h11000000, K_CFG, 32'h11000000, 4'h8}  // R6 top lane
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        io_req_i = 1'b0, io_we_i = 1'b0;
  logic [15:0] io_addr_i = '0;
  logic [1:0]  io_size_i = '0;
  logic [31:0] io_wdata_i = '0;
  logic        io_ack_o;
  logic [31:0] io_rdata_o;
  logic        cfg_req_o, cfg_we_o;
  logic [7:0]  cfg_bus_o;
  logic [4:0]  cfg_dev_o;
  logic [2:0]  cfg_func_o;
  logic [5:0]  cfg_reg_o;
  logic [3:0]  cfg_be_o;
  logic [31:0] cfg_wdata_o;
  logic        cfg_rsp_i = 1'b0;
  logic [31:0] cfg_rdata_i = '0;
  logic        fwd_req_o, fwd_we_o;
  logic [15:0] fwd_addr_o;
  logic [1:0]  fwd_size_o;
  logic [31:0] fwd_wdata_o;
  logic        fwd_ack_i = 1'b0;
  logic [31:0] fwd_rdata_i = '0;

  int checks = 0, failures = 0;

  int          r_cyc, n_cfg, n_fwd;
  logic [31:0] r_rdata, c_wdata, f_wdata;
  logic        c_we, f_we;
  logic [7:0]  c_bus;
  logic [4:0]  c_dev;
  logic [2:0]  c_func;
  logic [5:0]  c_reg;
  logic [3:0]  c_be;
  logic [15:0] f_addr;
  logic [1:0]  f_size;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cfg_port_decoder #(.TIMEOUT_CYC(TMO)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic txn(input logic we, input logic [15:0] addr, input logic [1:0] size,
                     input logic [31:0] wdata, input int cfg_lat, input int fwd_lat,
                     input logic [31:0] rsp);
    int  ccnt = 0, fcnt = 0;
    bit  cpend = 0, fstart = 0;
    @(negedge clk_i);
    io_req_i = 1'b1; io_we_i = we; io_addr_i = addr; io_size_i = size; io_wdata_i = wdata;
    @(negedge clk_i);
    io_req_i = 1'b0;
    n_cfg = 0; n_fwd = 0; r_cyc = -1; r_rdata = 'x;
    for (int cyc = 0; cyc < 2000; cyc++) begin
      cfg_rsp_i = 1'b0;
      fwd_ack_i = 1'b0;
      if (io_ack_o) begin
        r_cyc = cyc;
        r_rdata = io_rdata_o;
        break;
      end
      if (cfg_req_o) begin
        n_cfg++;
        c_we = cfg_we_o; c_bus = cfg_bus_o; c_dev = cfg_dev_o; c_func = cfg_func_o;
        c_reg = cfg_reg_o; c_be = cfg_be_o; c_wdata = cfg_wdata_o;
        cpend = 1; ccnt = cfg_lat;
      end
      if (cpend && cfg_lat >= 0) begin
        if (ccnt == 0) begin
          cfg_rsp_i = 1'b1; cfg_rdata_i = rsp; cpend = 0;
        end else ccnt--;
      end
      if (fwd_req_o && !fstart) begin
        n_fwd++; fstart = 1; fcnt = fwd_lat;
        f_we = fwd_we_o; f_addr = fwd_addr_o; f_size = fwd_size_o; f_wdata = fwd_wdata_o;
      end
      if (fstart && fcnt >= 0) begin
        if (fcnt == 0) begin
          fwd_ack_i = 1'b1; fwd_rdata_i = rsp;
        end
        fcnt--;
      end
      @(negedge clk_i);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] shadow;
    shadow = '0;
    repeat (3) @(negedge clk_i);
    // R1 outputs quiet in reset
    chk(!io_ack_o && !cfg_req_o && !fwd_req_o, "R1 reset idle",
        {29'd0, io_ack_o, cfg_req_o, fwd_req_o}, 32'd0);
    rst_ni = 1'b1;
    txn(1'b0, 16'h0CF8, 2'd2, '0, 2, 1, '0);
    chk(r_rdata == 32'h0, "R1 selector reset value", r_rdata, 32'h0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      txn(v.we, v.addr, v.size, v.wdata, 2, 1, v.rsp);
      if (v.kind == K_LOC) begin
        // R2 local claim, ack after one cycle
        chk(n_cfg == 0 && n_fwd == 0 && r_cyc == 0, "R2 local claim",
            32'(r_cyc), 32'd0);
        if (v.we) shadow = v.wdata & KEEP;
        else chk(r_rdata == v.exp_rdata, "R2 selector read", r_rdata, v.exp_rdata);
      end else if (v.kind == K_CFG) begin
        // R5 single request with selector fields; R7 latency
        chk(n_cfg == 1 && n_fwd == 0, "R5 one cfg request", 32'(n_cfg), 32'd1);
        chk({c_bus, c_dev, c_func, c_reg} == {shadow[23:16], shadow[15:11], shadow[10:8], shadow[7:2]},
            "R5 fields", {10'd0, c_bus, c_dev, c_func, c_reg},
            {10'd0, shadow[23:16], shadow[15:11], shadow[10:8], shadow[7:2]});
        chk(c_we == v.we, "R5 direction", 32'(c_we), 32'(v.we));
        chk(c_be == v.exp_be, "R6 byte enables", 32'(c_be), 32'(v.exp_be));
        chk(r_cyc == 3, "R7 ack after response", 32'(r_cyc), 32'd3);
        if (v.we) chk(c_wdata == v.wdata, "R7 write data", c_wdata, v.wdata);
        else chk(r_rdata == v.exp_rdata, "R7 read data", r_rdata, v.exp_rdata);
      end else begin
        // R3 R4 R10 forwarded unchanged; R9 return and latency
        chk(n_fwd == 1 && n_cfg == 0, "R3/R4/R10 forwarded", 32'(n_cfg), 32'd0);
        chk(f_addr == v.addr && f_size == v.size && f_we == v.we, "R3 forwarded fields",
            {13'd0, f_we, f_size, f_addr}, {13'd0, v.we, v.size, v.addr});
        chk(r_cyc == 2, "R9 forwarded ack", 32'(r_cyc), 32'd2);
        if (v.we) chk(f_wdata == v.wdata, "R3 forwarded data", f_wdata, v.wdata);
        else chk(r_rdata == v.exp_rdata, "R9 forwarded read", r_rdata, v.exp_rdata);
      end
    end

    // R8 silent target, read
    txn(1'b0, 16'h0CFC, 2'd2, '0, -1, 1, '0);
    chk(r_rdata == 32'hFFFF_FFFF, "R8 timeout read data", r_rdata, 32'hFFFF_FFFF);
    chk(r_cyc == TMO, "R8 timeout latency", 32'(r_cyc), 32'(TMO));
    // R8 silent target, write
    txn(1'b1, 16'h0CFC, 2'd2, 32'h5555AAAA, -1, 1, '0);
    chk(r_cyc == TMO && n_cfg == 1, "R8 timeout write", 32'(r_cyc), 32'(TMO));
    // R7 slower target
    txn(1'b0, 16'h0CFC, 2'd2, '0, 5, 1, 32'h0BADF00D);
    chk(r_cyc == 6 && r_rdata == 32'h0BADF00D, "R7 slow response", 32'(r_cyc), 32'd6);
    // R9 slower downstream
    txn(1'b0, 16'h0060, 2'd0, '0, 2, 4, 32'h000000C3);
    chk(r_cyc == 5 && r_rdata == 32'h000000C3, "R9 slow downstream", 32'(r_cyc), 32'd5);

    // R1 reset restores selector
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    txn(1'b0, 16'h0CF8, 2'd2, '0, 2, 1, '0);
    chk(r_rdata == 32'h0, "R1 selector after reset", r_rdata, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule